// File: doc/BRIEF.md
# Sign-Magnitude Rounding Unit

This block shortens a sign-magnitude value by dropping a parameterised number of low-order bits and choosing the kept field. The choice depends on one of four rounding rules. Three rules are directed: toward negative infinity, toward positive infinity and toward zero. The fourth is round-to-nearest with ties going to the even neighbour. The directed rules look at the sign as well as the magnitude, so a negative value and a positive value with the same magnitude can round in opposite directions. The datapath is purely combinational. The only state is the held two-bit rounding rule, which resets to round-to-nearest.

A caller feeds in the sign and a magnitude made of the kept field with the discarded bits appended below it. The block returns the rounded kept field, a separate carry for the case where rounding overflows the kept field, and a flag that reports any lost precision. The caller uses the carry to renormalise. Exponent handling belongs to the caller. When the discarded bits are the fractional part of a fixed-point number, the block rounds that number to an integer, as a store-to-integer path needs.

Top module: `round_unit`

## Requirements
- R1: A clock edge with `rst_n` low sets the held rule to round-to-nearest (code 00).
- R2: A clock edge with `mode_wr` high loads `mode_in` as the new rule. The new rule applies from that edge on. While `mode_wr` is low the rule is held. Codes: 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero.
- R3: `inexact_out` is 1 exactly when any of the low `DROP_W` bits of `mag_in` is nonzero.
- R4: When the dropped bits are all zero, `{carry_out, mag_out}` equals the kept field (the upper `KEEP_W` bits of `mag_in`) with a zero carry, for every rule and sign.
- R5: Under rule 00, the kept field is incremented when the top dropped bit is 1 and either some lower dropped bit is 1 or the kept LSB is 1. An exact half with an even kept field is left unchanged. So 23.5 (with four fraction bits) gives 24.
- R6: Under rule 01, the kept field is incremented only for a negative sign with `inexact_out` high. A positive value is truncated.
- R7: Under rule 10, the kept field is incremented only for a positive sign with `inexact_out` high. A negative value is truncated.
- R8: Under rule 11, the kept field is never incremented. So 23.5 gives 23.
- R9: `{carry_out, mag_out}` is the kept field plus the increment decision. An all-ones kept field that is incremented gives `carry_out` = 1 and `mag_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held rounding rule |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the rounding rule |
| mode_in | input | 2 | New rounding rule code |
| sign_in | input | 1 | Sign of the operand, 1 = negative |
| mag_in | input | KEEP_W+DROP_W | Magnitude, kept field above the dropped bits |
| mag_out | output | KEEP_W | Rounded kept field |
| carry_out | output | 1 | Carry out of the kept field after increment |
| inexact_out | output | 1 | Some dropped bit was nonzero |

## Verification
On every cycle, the assertions check four things:
- how the rule register loads, holds and resets;
- that an exact operand passes through unchanged;
- that the truncating and wrong-signed directed cases never increment;
- that a carry appears only from an all-ones kept field.

The nearest-even decision cannot be shown by a property. It needs the bench's scenarios: ties against near-ties on both parities, the worked examples, and a sweep over every dropped-bit pattern for each rule and sign, compared with an integer reference.

// File: rtl/rnd_pkg.sv
// Shared types for the rounding unit.
// Assumes: the rule encoding matches a two-bit control field.
package rnd_pkg;
    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_DOWN    = 2'b01,
        RND_UP      = 2'b10,
        RND_TRUNC   = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/rnd_mode_reg.sv
// Holds the active rounding rule.
// Assumes: synchronous active-low reset; a write takes effect from its edge.
module rnd_mode_reg
    import rnd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic [1:0] code_in,
    output rnd_mode_e mode_q
);
    // Rule register: reset to nearest-even, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= RND_NEAREST;
        else if (wr) mode_q <= rnd_mode_e'(code_in);
    end

    p_mode_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mode_q == RND_NEAREST);
    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> mode_q == rnd_mode_e'($past(code_in)));
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mode_q));
endmodule

// File: rtl/rnd_tail_reduce.sv
// Reduces the dropped bits to a guard bit and a sticky bit.
// Assumes: DROP_W >= 1; a single dropped bit has no sticky part.
module rnd_tail_reduce #(
    parameter int DROP_W = 4
) (
    input  logic [DROP_W-1:0] tail,
    output logic              guard,
    output logic              sticky
);
    assign guard = tail[DROP_W-1];

    generate
        if (DROP_W == 1) begin : g_no_sticky
            assign sticky = 1'b0;
        end else begin : g_sticky
            // Sticky: OR of every dropped bit below the guard.
            always_comb sticky = |tail[DROP_W-2:0];
        end
    endgenerate
endmodule

// File: rtl/rnd_decide.sv
// Chooses whether the kept field is incremented.
// Assumes: guard/sticky describe the dropped bits; sign 1 = negative.
module rnd_decide
    import rnd_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      sign,
    input  logic      lsb,
    input  logic      guard,
    input  logic      sticky,
    output logic      inc
);
    logic lost;
    assign lost = guard | sticky;

    // Increment decision per rule.
    always_comb begin
        unique case (mode)
            RND_NEAREST: inc = guard & (sticky | lsb);
            RND_DOWN:    inc = lost & sign;
            RND_UP:      inc = lost & ~sign;
            RND_TRUNC:   inc = 1'b0;
            default:     inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/rnd_increment.sv
// Adds the increment decision to the kept field and exposes the carry.
// Assumes: the caller renormalises on carry; the field is not wrapped silently.
module rnd_increment #(
    parameter int KEEP_W = 8
) (
    input  logic [KEEP_W-1:0] kept,
    input  logic              inc,
    output logic [KEEP_W-1:0] sum,
    output logic              carry
);
    // Ripple increment with carry out of the top bit.
    always_comb {carry, sum} = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
endmodule

// File: rtl/round_unit.sv
// Top: rounds a sign-magnitude operand to KEEP_W bits under a held rule.
// Assumes: mag_in carries the kept field above DROP_W discarded bits.
module round_unit
    import rnd_pkg::*;
#(
    parameter int KEEP_W = 8,
    parameter int DROP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_wr,
    input  logic [1:0]               mode_in,
    input  logic                     sign_in,
    input  logic [KEEP_W+DROP_W-1:0] mag_in,
    output logic [KEEP_W-1:0]        mag_out,
    output logic                     carry_out,
    output logic                     inexact_out
);
    localparam int IN_W = KEEP_W + DROP_W;

    rnd_mode_e         mode_q;
    logic [KEEP_W-1:0] kept;
    logic [DROP_W-1:0] tail;
    logic              guard, sticky, inc;

    assign kept = mag_in[IN_W-1:DROP_W];
    assign tail = mag_in[DROP_W-1:0];

    rnd_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .wr(mode_wr), .code_in(mode_in), .mode_q(mode_q)
    );

    rnd_tail_reduce #(.DROP_W(DROP_W)) u_tail (
        .tail(tail), .guard(guard), .sticky(sticky)
    );

    rnd_decide u_dec (
        .mode(mode_q), .sign(sign_in), .lsb(kept[0]),
        .guard(guard), .sticky(sticky), .inc(inc)
    );

    rnd_increment #(.KEEP_W(KEEP_W)) u_inc (
        .kept(kept), .inc(inc), .sum(mag_out), .carry(carry_out)
    );

    // Precision-loss flag from the reduced tail.
    always_comb inexact_out = guard | sticky;

    p_exact_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !inexact_out |-> ({carry_out, mag_out} == {1'b0, kept}));
    p_down_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RND_DOWN && !sign_in) |-> ({carry_out, mag_out} == {1'b0, kept}));
    p_up_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RND_UP && sign_in) |-> ({carry_out, mag_out} == {1'b0, kept}));
    p_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RND_TRUNC) |-> ({carry_out, mag_out} == {1'b0, kept}));
    p_carry_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (kept == {KEEP_W{1'b1}} && mag_out == '0));
endmodule

// File: tb/tb_round_unit.sv
module tb_round_unit;
    localparam int KW = 8;
    localparam int DW = 4;
    localparam int IW = KW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [1:0]    mode_in = 2'b00;
    logic          sign_in = 1'b0;
    logic [IW-1:0] mag_in = '0;
    logic [KW-1:0] mag_out;
    logic          carry_out, inexact_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    round_unit #(.KEEP_W(KW), .DROP_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .sign_in(sign_in), .mag_in(mag_in), .mag_out(mag_out),
        .carry_out(carry_out), .inexact_out(inexact_out)
    );

    // Vector: {mode, sign, mag_in, exp_mag, exp_carry, exp_inexact}
    localparam int NV = 16;
    localparam logic [24:0] VECS [NV] = '{
        {2'b00, 1'b0, 12'h0B8, 8'h0C, 1'b0, 1'b1},  // R5 +1.0111 nearest
        {2'b10, 1'b0, 12'h0B8, 8'h0C, 1'b0, 1'b1},  // R7 +1.0111 up
        {2'b01, 1'b0, 12'h0B8, 8'h0B, 1'b0, 1'b1},  // R6 +1.0111 down
        {2'b11, 1'b0, 12'h0B8, 8'h0B, 1'b0, 1'b1},  // R8 +1.0111 trunc
        {2'b00, 1'b1, 12'h0B8, 8'h0C, 1'b0, 1'b1},  // R5 -1.0111 nearest
        {2'b01, 1'b1, 12'h0B8, 8'h0C, 1'b0, 1'b1},  // R6 -1.0111 down
        {2'b10, 1'b1, 12'h0B8, 8'h0B, 1'b0, 1'b1},  // R7 -1.0111 up
        {2'b11, 1'b1, 12'h0B8, 8'h0B, 1'b0, 1'b1},  // R8 -1.0111 trunc
        {2'b00, 1'b0, 12'h178, 8'h18, 1'b0, 1'b1},  // R5 23.5 -> 24
        {2'b11, 1'b0, 12'h178, 8'h17, 1'b0, 1'b1},  // R8 23.5 -> 23
        {2'b00, 1'b0, 12'h0A8, 8'h0A, 1'b0, 1'b1},  // R5 tie even stays
        {2'b00, 1'b0, 12'h0A9, 8'h0B, 1'b0, 1'b1},  // R5 above tie
        {2'b00, 1'b0, 12'h0A7, 8'h0A, 1'b0, 1'b1},  // R5 below tie
        {2'b00, 1'b0, 12'hFFF, 8'h00, 1'b1, 1'b1},  // R9 carry out
        {2'b10, 1'b1, 12'hFF0, 8'hFF, 1'b0, 1'b0},  // R4 exact
        {2'b01, 1'b1, 12'hFF1, 8'h00, 1'b1, 1'b1}   // R9 down negative carry
    };

    task automatic check(input string req, input logic [KW-1:0] em,
                         input logic ec, input logic ei);
        checks++;
        if (mag_out !== em || carry_out !== ec || inexact_out !== ei) begin
            errors++;
            $display("FAIL %s: got mag=%h c=%b x=%b, expected mag=%h c=%b x=%b",
                     req, mag_out, carry_out, inexact_out, em, ec, ei);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_in = m;
        mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic apply(input logic s, input logic [IW-1:0] m);
        @(negedge clk);
        sign_in = s;
        mag_in  = m;
        #2;
    endtask

    // Integer reference for one operand under one rule.
    function automatic logic [KW:0] ref_round(input logic [1:0] m, input logic s,
                                              input int unsigned v);
        int unsigned q = v / (1 << DW);
        int unsigned r = v % (1 << DW);
        int unsigned half = 1 << (DW - 1);
        bit up;
        case (m)
            2'b00:   up = (r > half) || (r == half && (q % 2) == 1);
            2'b01:   up = (r != 0) && s;
            2'b10:   up = (r != 0) && !s;
            default: up = 1'b0;
        endcase
        return (KW+1)'(q + (up ? 1 : 0));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset rule is nearest: odd tie rounds up
        apply(1'b0, 12'h0B8);
        check("R1", 8'h0C, 1'b0, 1'b1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            set_mode(VECS[i][24:23]);
            apply(VECS[i][22], VECS[i][21:10]);
            check($sformatf("R%0s vec%0d", "5-9", i), VECS[i][9:2], VECS[i][1], VECS[i][0]);
        end

        // R2: held when strobe low
        set_mode(2'b11);
        @(negedge clk);
        mode_in = 2'b00;
        repeat (2) @(negedge clk);
        apply(1'b0, 12'h0BF);
        check("R2 hold", 8'h0B, 1'b0, 1'b1);

        // R1: reset after a write returns to nearest
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 12'h0BF);
        check("R1 rereset", 8'h0C, 1'b0, 1'b1);

        // R3/R4/R5/R6/R7/R8/R9 sweep against integer reference
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            for (int s = 0; s < 2; s++) begin
                for (int b = 0; b < 3; b++) begin
                    for (int t = 0; t < 16; t++) begin
                        logic [KW-1:0] base;
                        logic [KW:0] exp;
                        base = (b == 0) ? 8'h0A : (b == 1) ? 8'h0B : 8'hFF;
                        exp  = ref_round(2'(m), s[0], {base, 4'(t)});
                        apply(s[0], {base, 4'(t)});
                        check("R3 R4 R5 R6 R7 R8 R9 sweep", exp[KW-1:0], exp[KW], t != 0);
                    end
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule